// File: doc/BRIEF.md
# Acknowledge-Polling Bus Master

This block is the master side of a two-wire serial bus. It waits for a serial memory to finish its internal nonvolatile write cycle. A memory that is busy writing does not answer its address. The block therefore probes the device again and again: each probe is a START, one address byte and an acknowledge sample. It keeps probing until the device answers or a retry budget runs out. Probing may begin right after the STOP that closed the byte load.

A single `go` pulse launches the loop. The 7-bit device address and the direction bit are captured at that moment. Every probe drives the bus through open-drain controls, where a 1 pulls the line low. A probe the device ignores ends with STOP, and a new probe follows at once. A probe the device acknowledges also ends with STOP, and `done` then pulses so the caller can go on with its real command. If `MAX_TRIES` probes in a row get no acknowledge, `timeout` pulses instead and the bus is left idle. Bit timing comes from a divider: each bit is split into four quarters of `QDIV` clocks each.

Top module: `ackpoll_master`

## Requirements
- R1: Out of reset, and whenever `busy` is low, both bus controls are released (`scl_oe`=0, `sda_oe`=0) and `done`, `timeout` and `busy` are low.
- R2: A probe begins only with a START: SDA falls while SCL is high, before any SCL clock pulse of that probe.
- R3: After the START the byte `{dev_addr, rd_wr}` is sent most significant bit first, one bit per SCL high period, using the values captured at `go`.
- R4: The master releases SDA during the ninth SCL clock of a probe, and an SDA level of 0 sampled in that clock counts as an acknowledge.
- R5: A probe with no acknowledge ends with a STOP (SDA rises while SCL is high), and the next probe's START follows.
- R6: A probe with an acknowledge ends with a STOP. `done` then goes high for exactly one clock, in the same cycle that `busy` drops.
- R7: After `MAX_TRIES` probes without an acknowledge, `timeout` goes high for exactly one clock, `busy` drops, and no further START appears. `done` and `timeout` are never high together.
- R8: For each of the nine data and acknowledge clocks, SCL stays high for exactly 2*`QDIV` clocks and low for exactly 2*`QDIV` clocks before its rise.
- R9: While SCL stays high, SDA changes only as a START or STOP edge, never within a data or acknowledge clock.
- R10: A `go` pulse while `busy` is high is ignored: the running probes keep the captured address, and nothing further is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go | input | 1 | One-clock request to start polling |
| dev_addr | input | 7 | Device address, captured on an accepted `go` |
| rd_wr | input | 1 | Direction bit sent after the address, captured with it |
| sda_in | input | 1 | Sampled level of the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low; 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| busy | output | 1 | High while a polling loop is running |
| done | output | 1 | One-clock pulse: the device acknowledged |
| timeout | output | 1 | One-clock pulse: retry budget used up |

## Verification
A wrong quarter or slot counter shows up within one bit time, 4*`QDIV` clocks. It appears as an SCL period of the wrong length or as SDA moving while SCL is high. A fault in the shift path or the captured frame shows as a wrong byte on the bus in the very first probe. A fault in acknowledge sampling or the retry count appears only at the end of a loop. It shows as the wrong number of STARTs before `done` or `timeout`, or as the wrong one of the two pulses. So the bench counts probes against a device model that answers on a chosen probe, including the first probe, the last allowed one and never.

// File: rtl/ap_pkg.sv
// Shared types for the acknowledge-polling master.
// Assumes: one probe is a fixed sequence of slots, each four quarters long.
package ap_pkg;

    // Slot of a probe; each slot spans four quarter phases
    typedef enum logic [1:0] {
        SLOT_START = 2'd0,
        SLOT_BIT   = 2'd1,
        SLOT_ACK   = 2'd2,
        SLOT_STOP  = 2'd3
    } slot_e;

endpackage

// File: rtl/ap_qtick.sv
// Quarter-phase tick generator.
// Emits a one-clock tick every QDIV clocks while run is high; it restarts
// from zero whenever run is low, so the first quarter after a launch is full length.
module ap_qtick #(
    parameter int QDIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

    logic [CW-1:0] cnt_q;

    // Count clocks within a quarter; hold at zero while idle
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == LAST);

endmodule

// File: rtl/ap_retry.sv
// Probe counter.
// Counts failed probes since the last launch. Assumes clear and bump are
// never high in the same clock; clear wins if they are.
module ap_retry #(
    parameter int MAX_TRIES = 8,
    localparam int TW = $clog2(MAX_TRIES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          bump,
    output logic [TW-1:0] count
);
    // Reset on launch, step on each unanswered probe
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
        end else if (bump) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/ap_shift.sv
// Frame holder and serialiser.
// Captures the address byte on load and presents it MSB first on cur_bit.
// Reload restores the captured byte for the next probe; shift moves to the next bit.
module ap_shift #(
    parameter int FRAME_W = 8,
    localparam int CNT_W = $clog2(FRAME_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic               reload,
    input  logic               shift,
    output logic               cur_bit,
    output logic               last_bit
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);

    logic [FRAME_W-1:0] frame_q;
    logic [FRAME_W-1:0] shreg_q;
    logic [CNT_W-1:0]   idx_q;

    // Hold the captured byte for the whole loop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
        end else if (load) begin
            frame_q <= frame_in;
        end
    end

    // Serialise the byte, restarting it for every probe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            idx_q   <= '0;
        end else if (load) begin
            shreg_q <= frame_in;
            idx_q   <= '0;
        end else if (reload) begin
            shreg_q <= frame_q;
            idx_q   <= '0;
        end else if (shift) begin
            shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
            idx_q   <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
        end
    end

    assign cur_bit  = shreg_q[FRAME_W-1];
    assign last_bit = (idx_q == LAST_IDX);

endmodule

// File: rtl/ap_seq.sv
// Probe sequencer.
// Walks START, eight bit slots, ACK and STOP, each four quarters long, and
// drives registered open-drain controls. SCL is released in quarters 2-3 of
// clocked slots. SDA moves in quarter 1 (SCL low), except for the START fall
// (START quarter 2) and the STOP rise (STOP quarter 3).
// Assumes: tick is a one-clock pulse; sda_in is already synchronous.
module ap_seq
    import ap_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  go,
    input  logic  tick,
    input  logic  sda_in,
    input  logic  cur_bit,
    input  logic  last_bit,
    input  logic  last_try,
    output logic  busy,
    output logic  done,
    output logic  timeout,
    output logic  scl_low,
    output logic  sda_low,
    output logic  load,
    output logic  reload,
    output logic  try_fail,
    output slot_e slot,
    output logic [1:0] qtr
);
    slot_e      slot_q, nslot;
    logic [1:0] q_q, nq;
    logic       busy_q, acked_q, done_q, to_q;
    logic       scl_q, sda_q;
    logic       wrap, end_attempt;

    // Next slot and quarter, applied only on a tick
    always_comb begin
        wrap  = (q_q == 2'd3);
        nq    = q_q + 2'd1;
        nslot = slot_q;
        if (wrap) begin
            unique case (slot_q)
                SLOT_START: nslot = SLOT_BIT;
                SLOT_BIT:   nslot = last_bit ? SLOT_ACK : SLOT_BIT;
                SLOT_ACK:   nslot = SLOT_STOP;
                SLOT_STOP:  nslot = SLOT_START;
                default:    nslot = SLOT_START;
            endcase
        end
    end

    assign end_attempt = busy_q && tick && wrap && (slot_q == SLOT_STOP);
    assign load        = go && !busy_q;
    assign try_fail    = end_attempt && !acked_q;
    assign reload      = try_fail && !last_try;

    // Probe state, bus drive and completion pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            slot_q  <= SLOT_START;
            q_q     <= 2'd0;
            acked_q <= 1'b0;
            done_q  <= 1'b0;
            to_q    <= 1'b0;
            scl_q   <= 1'b0;
            sda_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            to_q   <= 1'b0;
            if (!busy_q) begin
                if (go) begin
                    busy_q  <= 1'b1;
                    slot_q  <= SLOT_START;
                    q_q     <= 2'd0;
                    acked_q <= 1'b0;
                end
            end else if (tick) begin
                q_q    <= nq;
                slot_q <= nslot;
                if (slot_q == SLOT_ACK && q_q == 2'd2) begin
                    acked_q <= !sda_in;
                end
                unique case (nq)
                    2'd0: begin
                        if (nslot != SLOT_START) scl_q <= 1'b1;
                    end
                    2'd1: begin
                        if (nslot == SLOT_BIT)       sda_q <= !cur_bit;
                        else if (nslot == SLOT_ACK)  sda_q <= 1'b0;
                        else if (nslot == SLOT_STOP) sda_q <= 1'b1;
                    end
                    2'd2: begin
                        scl_q <= 1'b0;
                        if (nslot == SLOT_START) sda_q <= 1'b1;
                    end
                    default: begin
                        if (nslot == SLOT_STOP) sda_q <= 1'b0;
                    end
                endcase
                if (end_attempt) begin
                    acked_q <= 1'b0;
                    if (acked_q) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end else if (last_try) begin
                        busy_q <= 1'b0;
                        to_q   <= 1'b1;
                    end
                end
            end
        end
    end

    assign busy    = busy_q;
    assign done    = done_q;
    assign timeout = to_q;
    assign scl_low = scl_q;
    assign sda_low = sda_q;
    assign slot    = slot_q;
    assign qtr     = q_q;

endmodule

// File: rtl/ackpoll_master.sv
// Acknowledge-polling bus master, top level.
// Repeats START + address byte + ACK sample + STOP until the device answers
// or MAX_TRIES probes fail. Bus pins are open-drain controls (1 = pull low).
// Assumes: sda_in is synchronised to clk outside this block; no clock stretching.
module ackpoll_master #(
    parameter int QDIV      = 4,
    parameter int MAX_TRIES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [6:0] dev_addr,
    input  logic       rd_wr,
    input  logic       sda_in,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic       busy,
    output logic       done,
    output logic       timeout
);
    import ap_pkg::*;

    localparam int TW = $clog2(MAX_TRIES + 1);
    localparam logic [TW-1:0] LAST_TRY = TW'(MAX_TRIES - 1);

    logic          qtick, cur_bit, last_bit, last_try;
    logic          load, reload, try_fail, shift_en;
    logic [TW-1:0] tries;
    slot_e         slot_w;
    logic [1:0]    qtr_w;

    ap_qtick #(.QDIV(QDIV)) u_qtick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .tick (qtick)
    );

    ap_retry #(.MAX_TRIES(MAX_TRIES)) u_retry (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(load),
        .bump (try_fail),
        .count(tries)
    );

    assign last_try = (tries == LAST_TRY);
    assign shift_en = qtick && (slot_w == SLOT_BIT) && (qtr_w == 2'd3);

    ap_shift #(.FRAME_W(8)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .frame_in({dev_addr, rd_wr}),
        .reload  (reload),
        .shift   (shift_en),
        .cur_bit (cur_bit),
        .last_bit(last_bit)
    );

    ap_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .tick    (qtick),
        .sda_in  (sda_in),
        .cur_bit (cur_bit),
        .last_bit(last_bit),
        .last_try(last_try),
        .busy    (busy),
        .done    (done),
        .timeout (timeout),
        .scl_low (scl_oe),
        .sda_low (sda_oe),
        .load    (load),
        .reload  (reload),
        .try_fail(try_fail),
        .slot    (slot_w),
        .qtr     (qtr_w)
    );

endmodule

// File: rtl/ackpoll_master_chk.sv
// Property checker for ackpoll_master, attached by bind below.
// Assumes it sees the sequencer slot, quarter and probe count of the top.
module ackpoll_master_chk
    import ap_pkg::*;
#(
    parameter int MAX_TRIES = 8,
    localparam int TW = $clog2(MAX_TRIES + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_oe,
    input logic          sda_oe,
    input logic          busy,
    input logic          done,
    input logic          timeout,
    input slot_e         slot,
    input logic [1:0]    qtr,
    input logic [TW-1:0] tries
);
    // R1
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_oe && !sda_oe));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7
    to_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> !timeout);

    // R7
    to_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && timeout));

    // R7
    try_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (tries < TW'(MAX_TRIES)));

    // R4
    ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && slot == SLOT_ACK && qtr != 2'd0) |-> !sda_oe);

    // R9
    sda_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && $past(!scl_oe) && !$stable(sda_oe))
            |-> (slot == SLOT_START || slot == SLOT_STOP));

endmodule

bind ackpoll_master ackpoll_master_chk #(.MAX_TRIES(MAX_TRIES)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_oe (scl_oe),
    .sda_oe (sda_oe),
    .busy   (busy),
    .done   (done),
    .timeout(timeout),
    .slot   (slot_w),
    .qtr    (qtr_w),
    .tries  (tries)
);

// File: tb/ackpoll_master_test.sv
module ackpoll_master_test;
    localparam int QDIV      = 4;
    localparam int MAX_TRIES = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       go = 1'b0;
    logic [6:0] dev_addr = '0;
    logic       rd_wr = 1'b0;
    logic       scl_oe, sda_oe, busy, done, timeout;
    logic       slv_pull = 1'b0;
    wire        scl_l = !scl_oe;
    wire        sda_l = !sda_oe && !slv_pull;

    int total = 0;
    int bad = 0;

    // bus monitor / device model state
    int   n_start, n_stop, byte_bad, sda_viol, tim_bad, ack_viol, stray;
    int   bitc, hi_len, lo_len, ack_idx;
    logic in_frame, pscl, psda;
    logic [7:0] shreg, exp_byte;

    ackpoll_master #(.QDIV(QDIV), .MAX_TRIES(MAX_TRIES)) uut (
        .clk(clk), .rst_n(rst_n), .go(go), .dev_addr(dev_addr), .rd_wr(rd_wr),
        .sda_in(sda_l), .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy),
        .done(done), .timeout(timeout)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_tries(input int at);
        return (at < MAX_TRIES) ? at + 1 : MAX_TRIES;
    endfunction

    // Bus monitor and acknowledging device, sampled on the falling clock edge
    always @(negedge clk) begin
        if (!rst_n) begin
            pscl = 1'b1; psda = 1'b1; in_frame = 1'b0; bitc = 0;
            slv_pull = 1'b0; hi_len = 0; lo_len = 0;
        end else begin
            if (pscl && scl_l && psda && !sda_l) begin
                n_start++; in_frame = 1'b1; bitc = 0; shreg = '0;
            end else if (pscl && scl_l && !psda && sda_l) begin
                n_stop++; in_frame = 1'b0; slv_pull = 1'b0;
            end else if (pscl && scl_l && (psda != sda_l)) begin
                sda_viol++;
            end
            if (!pscl && scl_l) begin
                if (!in_frame) stray++;
                else begin
                    bitc++;
                    if (bitc <= 9 && lo_len != 2*QDIV) tim_bad++;
                    if (bitc <= 8) shreg = {shreg[6:0], sda_l};
                    if (bitc == 8 && shreg != exp_byte) byte_bad++;
                    if (bitc == 9 && sda_oe) ack_viol++;
                end
                hi_len = 0;
            end
            if (pscl && !scl_l) begin
                if (in_frame && bitc >= 1 && bitc <= 9 && hi_len != 2*QDIV) tim_bad++;
                if (in_frame && bitc == 8 && (n_start - 1) == ack_idx) slv_pull = 1'b1;
                if (bitc == 9) slv_pull = 1'b0;
                lo_len = 0;
            end
            if (scl_l) hi_len++; else lo_len++;
            pscl = scl_l; psda = sda_l;
        end
    end

    task automatic run_poll(input logic [6:0] a, input logic r, input int at, input bit poke);
        bit got_done, got_to;
        int cyc, s0;
        exp_byte = {a, r}; ack_idx = at;
        n_start = 0; n_stop = 0; byte_bad = 0; sda_viol = 0;
        tim_bad = 0; ack_viol = 0; stray = 0;
        dev_addr = a; rd_wr = r; go = 1'b1;
        @(posedge clk); #1; go = 1'b0;
        cyc = 0;
        while (!(done || timeout) && cyc < 4000) begin
            if (poke && cyc == 300) begin go = 1'b1; dev_addr = ~a; rd_wr = ~r; end
            if (poke && cyc == 301) begin go = 1'b0; dev_addr = a; rd_wr = r; end
            @(posedge clk); #1; cyc++;
        end
        got_done = done; got_to = timeout;
        chk(busy == 1'b0, "R6/R7 busy low with completion pulse", busy, 0);
        @(posedge clk); #1;
        chk(!done && !timeout, "R6/R7 single-cycle pulse", {done, timeout}, 0);
        chk(n_start == exp_tries(at), "R5 probe count", n_start, exp_tries(at));
        chk(n_stop == n_start, "R5/R6 each probe ends with STOP", n_stop, n_start);
        chk(byte_bad == 0, "R3 address byte MSB first", byte_bad, 0);
        chk(ack_viol == 0, "R4 SDA released on ninth clock", ack_viol, 0);
        chk(sda_viol == 0, "R9 SDA stable while SCL high", sda_viol, 0);
        chk(tim_bad == 0, "R8 SCL high/low lengths", tim_bad, 0);
        chk(stray == 0, "R2 no clock before START", stray, 0);
        chk(got_done == (at < MAX_TRIES), "R6 done on acknowledge", got_done, at < MAX_TRIES);
        chk(got_to == (at >= MAX_TRIES), "R7 timeout on budget", got_to, at >= MAX_TRIES);
        if (got_to || poke) begin
            s0 = n_start;
            repeat (400) @(posedge clk);
            #1;
            chk(n_start == s0, poke ? "R10 nothing queued by ignored go" : "R7 no probe after timeout",
                n_start, s0);
            chk(!busy && !scl_oe && !sda_oe, "R1 idle bus after loop", {busy, scl_oe, sda_oe}, 0);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (4) @(posedge clk);
        #1;
        chk(!scl_oe && !sda_oe && !busy && !done && !timeout, "R1 reset state",
            {scl_oe, sda_oe, busy, done, timeout}, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk(!scl_oe && !sda_oe && !busy, "R1 idle after reset", {scl_oe, sda_oe, busy}, 0);
        // directed corners
        run_poll(7'h50, 1'b0, 0, 1'b0);                 // first probe answered
        run_poll(7'h2A, 1'b1, MAX_TRIES - 1, 1'b0);     // last allowed probe answered
        run_poll(7'h7F, 1'b1, MAX_TRIES, 1'b0);         // never answered: timeout
        run_poll(7'h00, 1'b0, 2, 1'b1);                 // R10 go while busy
        // constrained random
        for (int i = 0; i < 12; i++) begin
            run_poll(7'($urandom_range(0, 127)), 1'($urandom_range(0, 1)),
                     int'($urandom_range(0, MAX_TRIES)), 1'b0);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule